// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function I/O device. Software reaches it through two byte-wide ports on a small address bus: an index port that selects a configuration register, and a data port that reads or writes the selected register. After reset the port is locked. Software must write a four-byte key, in order, to the index port before any configuration register can be reached. Until then, data-port reads return all ones and data-port writes have no effect.

Once unlocked, the index register selects either a global register or a banked register. The global registers are the logical-device select, a 16-bit identity and a revision nibble. The banked registers belong to the logical device chosen by the select register: an activate bit and a 16-bit base address. Each bank's state is brought out on output buses for the logical devices that the block serves. Writing the exit code to the exit index locks the port again. Reads are combinational and have no side effects.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the port is locked (`cfg_open` low), the logical-device select is 0x00, every activate bit is 0 and every base address is 0x0000.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) while locked raises `cfg_open` on the clock edge that captures the fourth byte.
- R3: A byte that does not match the next key byte sends the matcher back to its start. If that byte is 0x87, it counts as the first key byte. Index writes made while locked do not change the index register.
- R4: While locked, a read of the data port (address 0x2F) returns 0xFF, and a data-port write changes no register and no output.
- R5: When unlocked, data reads at index 0x20 return identity bits 15:8, at index 0x21 identity bits 7:0, and at index 0x22 the value {4'h0, revision}. Writes to these three indexes are ignored.
- R6: Index 0x07 holds the 8-bit logical-device select. It reads back through the data port and is driven on `ldn_sel`.
- R7: Index 0x30 is the activate register of the selected bank. A write stores data bit 0, which appears on `dev_active[ldn]`. A read returns {7'b0, bit}. Other banks are unaffected.
- R8: Index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the selected bank's base address. The base address appears on `dev_base[16*ldn +: 16]` and reads back through the data port.
- R9: When the select value is NUM_DEV or greater, banked reads return 0x00 and banked writes change nothing.
- R10: When unlocked, a data write of 0x02 at index 0x02 locks the port on that edge. Any other data value written at index 0x02 leaves the port open.
- R11: With `bus_rd` high, an index-port read returns the current index when unlocked and 0xFF when locked. A data read at an unassigned index returns 0x00. With `bus_rd` low, or at any other address, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read enable; data returned the same cycle |
| bus_addr | input | ADDR_W | Port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cfg_open | output | 1 | High while configuration access is unlocked |
| ldn_sel | output | 8 | Current logical-device select |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device i at bits 16*i+15:16*i |

## Verification
The hardest state to reach from the ports is the key matcher partway through a sequence when an unexpected byte arrives. This matters most when that byte is itself the first key byte, because the matcher's step count cannot be seen from outside. The bench reaches every such state by sweeping all 256 byte values into each of the three positions after a correct prefix. It then checks whether the port opened, and confirms that a fresh key still unlocks from whatever step the matcher was left in.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam int          KEY_LEN     = 4;
   localparam logic [7:0]  IX_EXIT     = 8'h02;
   localparam logic [7:0]  EXIT_CODE   = 8'h02;
   localparam logic [7:0]  IX_LDN      = 8'h07;
   localparam logic [7:0]  IX_ID_HI    = 8'h20;
   localparam logic [7:0]  IX_ID_LO    = 8'h21;
   localparam logic [7:0]  IX_REV      = 8'h22;
   localparam logic [7:0]  IX_ACT      = 8'h30;
   localparam logic [7:0]  IX_BASE_HI  = 8'h60;
   localparam logic [7:0]  IX_BASE_LO  = 8'h61;

   typedef struct packed {
      logic        act;
      logic [15:0] base;
   } bank_t;

   // unlock key, in order of arrival
   function automatic logic [7:0] key_byte(input int unsigned pos);
      case (pos)
         0:       key_byte = 8'h87;
         1:       key_byte = 8'h01;
         default: key_byte = 8'h55;
      endcase
   endfunction
endpackage

// File: rtl/cfgport_key_match.sv
module cfgport_key_match
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   output logic       key_done
);
   localparam int STEP_W = $clog2(KEY_LEN);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

   logic [STEP_W-1:0] step_q;
   logic              match;

   assign match    = (byte_in == key_byte(int'(step_q)));
   assign key_done = byte_vld && match && (step_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (byte_vld) begin
         if (match)
            step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
         else if (byte_in == key_byte(0))
            step_q <= STEP_W'(1);
         else
            step_q <= '0;
      end
   end
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       wr_act,
   input  logic       wr_hi,
   input  logic       wr_lo,
   input  logic [7:0] wdata,
   output bank_t      st
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else if (sel) begin
         if (wr_act) st.act        <= wdata[0];
         if (wr_hi)  st.base[15:8] <= wdata;
         if (wr_lo)  st.base[7:0]  <= wdata;
      end
   end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
   import cfgport_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] INDEX_ADDR = ADDR_W'('h2E),
   parameter logic [ADDR_W-1:0] DATA_ADDR  = ADDR_W'('h2F),
   parameter int                NUM_DEV    = 4,
   parameter logic [15:0]       CHIP_ID    = 16'h5A31,
   parameter logic [3:0]        CHIP_REV   = 4'h3
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   output logic                  cfg_open,
   output logic [7:0]            ldn_sel,
   output logic [NUM_DEV-1:0]    dev_active,
   output logic [16*NUM_DEV-1:0] dev_base
);
   localparam int LDN_SPAN = 256;

   // elaboration-time parameter checks
   if (NUM_DEV < 1 || NUM_DEV > LDN_SPAN) begin : g_bad_ndev
      $error("cfgport_ctrl: NUM_DEV must lie in 1..256");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("cfgport_ctrl: ADDR_W too small");
   end
   if (INDEX_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("cfgport_ctrl: index and data ports must differ");
   end

   logic       open_q;
   logic [7:0] idx_q;
   logic [7:0] ldn_q;
   logic       at_idx, at_dat, idx_wr, dat_wr, key_done, ldn_ok;
   bank_t      banks [NUM_DEV];
   bank_t      cur_bank;
   logic [7:0] reg_val;

   assign at_idx = (bus_addr == INDEX_ADDR);
   assign at_dat = (bus_addr == DATA_ADDR);
   assign idx_wr = bus_wr && at_idx;
   assign dat_wr = bus_wr && at_dat && open_q;

   cfgport_key_match key_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (idx_wr && !open_q),
      .byte_in  (bus_wdata),
      .key_done (key_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         idx_q  <= 8'h00;
         ldn_q  <= 8'h00;
      end else begin
         if (key_done)
            open_q <= 1'b1;
         else if (dat_wr && idx_q == IX_EXIT && bus_wdata == EXIT_CODE)
            open_q <= 1'b0;
         if (idx_wr && open_q)
            idx_q <= bus_wdata;
         if (dat_wr && idx_q == IX_LDN)
            ldn_q <= bus_wdata;
      end
   end

   // selected device in range: variant chosen by bank count
   if (NUM_DEV >= LDN_SPAN) begin : g_full_span
      assign ldn_ok = 1'b1;
   end else begin : g_part_span
      assign ldn_ok = (int'(ldn_q) < NUM_DEV);
   end

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
      cfgport_bank bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (dat_wr && ldn_ok && ldn_q == 8'(g)),
         .wr_act (idx_q == IX_ACT),
         .wr_hi  (idx_q == IX_BASE_HI),
         .wr_lo  (idx_q == IX_BASE_LO),
         .wdata  (bus_wdata),
         .st     (banks[g])
      );
      assign dev_active[g]         = banks[g].act;
      assign dev_base[16*g +: 16]  = banks[g].base;
   end

   always_comb begin
      cur_bank = '0;
      for (int i = 0; i < NUM_DEV; i++)
         if (ldn_q == 8'(i)) cur_bank = banks[i];
   end

   always_comb begin
      case (idx_q)
         IX_LDN:     reg_val = ldn_q;
         IX_ID_HI:   reg_val = CHIP_ID[15:8];
         IX_ID_LO:   reg_val = CHIP_ID[7:0];
         IX_REV:     reg_val = {4'h0, CHIP_REV};
         IX_ACT:     reg_val = {7'h00, cur_bank.act};
         IX_BASE_HI: reg_val = cur_bank.base[15:8];
         IX_BASE_LO: reg_val = cur_bank.base[7:0];
         default:    reg_val = 8'h00;
      endcase
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd) begin
         if (at_idx)      bus_rdata = open_q ? idx_q   : 8'hFF;
         else if (at_dat) bus_rdata = open_q ? reg_val : 8'hFF;
      end
   end

   assign cfg_open = open_q;
   assign ldn_sel  = ldn_q;
endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] INDEX_ADDR = ADDR_W'('h2E),
   parameter logic [ADDR_W-1:0] DATA_ADDR  = ADDR_W'('h2F),
   parameter int                NUM_DEV    = 4,
   parameter logic [7:0]        ID_HI      = 8'h5A
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [7:0]            bus_wdata,
   input logic [7:0]            bus_rdata,
   input logic                  cfg_open,
   input logic [NUM_DEV-1:0]    dev_active,
   input logic [16*NUM_DEV-1:0] dev_base,
   input logic [7:0]            idx_q
);
   assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(bus_wr && bus_addr == INDEX_ADDR && bus_wdata == 8'h55));

   assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !cfg_open && bus_addr == DATA_ADDR) |-> bus_rdata == 8'hFF);

   assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && bus_wr && bus_addr == DATA_ADDR)
      |=> ($stable(dev_active) && $stable(dev_base) && !cfg_open));

   assert_id_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && cfg_open && bus_addr == DATA_ADDR && idx_q == 8'h20) |-> bus_rdata == ID_HI);

   assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_open |=> $countones(dev_active ^ $past(dev_active)) <= 1);

   assert_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && bus_wr && bus_addr == DATA_ADDR && idx_q == 8'h02 && bus_wdata == 8'h02)
      |=> !cfg_open);

   assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == 8'h00);
endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .INDEX_ADDR (INDEX_ADDR),
   .DATA_ADDR  (DATA_ADDR),
   .NUM_DEV    (NUM_DEV),
   .ID_HI      (CHIP_ID[15:8])
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .cfg_open   (cfg_open),
   .dev_active (dev_active),
   .dev_base   (dev_base),
   .idx_q      (idx_q)
);

// File: tb/cfgport_ctrl_tb.sv
module cfgport_ctrl_tb_top;
   localparam int          NDEV = 4;
   localparam logic [15:0] IDX  = 16'h002E;
   localparam logic [15:0] DAT  = 16'h002F;
   localparam logic [15:0] CID  = 16'h5A31;
   localparam logic [3:0]  CREV = 4'h3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0]         bus_addr = '0;
   logic [7:0]          bus_wdata = '0;
   logic [7:0]          bus_rdata;
   logic                cfg_open;
   logic [7:0]          ldn_sel;
   logic [NDEV-1:0]     dev_active;
   logic [16*NDEV-1:0]  dev_base;

   int n_chk = 0, n_err = 0;
   logic [NDEV-1:0]    exp_act;
   logic [16*NDEV-1:0] exp_base;
   logic [7:0]         rv;

   always #10 clk = ~clk;

   cfgport_ctrl #(.NUM_DEV(NDEV), .CHIP_ID(CID), .CHIP_REV(CREV)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_open(cfg_open), .ldn_sel(ldn_sel), .dev_active(dev_active),
      .dev_base(dev_base)
   );

   function automatic logic [7:0] kb(input int p);
      return (p == 0) ? 8'h87 : (p == 1) ? 8'h01 : 8'h55;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #2 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic unlock();
      for (int j = 0; j < 4; j++) wr(IDX, kb(j));
   endtask

   task automatic relock();
      wr(IDX, 8'h02); wr(DAT, 8'h02);
   endtask

   task automatic setreg(input logic [7:0] ix, input logic [7:0] v);
      wr(IDX, ix); wr(DAT, v);
   endtask

   task automatic getreg(input logic [7:0] ix, output logic [7:0] v);
      wr(IDX, ix); rd(DAT, v);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 cfg_open", cfg_open, 0);
      check("R1 ldn_sel", ldn_sel, 0);
      check("R1 dev_active", dev_active, 0);
      check("R1 dev_base", dev_base, 0);
      rd(DAT, rv); check("R4 locked data read", rv, 8'hFF);
      rd(IDX, rv); check("R11 locked index read", rv, 8'hFF);
      #3 check("R11 idle rdata", bus_rdata, 0);

      // R4 locked data writes
      for (int v = 0; v < 8; v++) wr(DAT, 8'(v) | 8'h01);
      check("R4 locked write open", cfg_open, 0);
      check("R4 locked write act", dev_active, 0);
      check("R4 locked write base", dev_base, 0);

      // R2/R3 sweep of every byte into each key position
      for (int k = 1; k <= 3; k++) begin
         for (int v = 0; v < 256; v++) begin
            for (int j = 0; j < k; j++) wr(IDX, kb(j));
            wr(IDX, 8'(v));
            if (k == 3 && v == 8'h55) check("R2 key opens", cfg_open, 1);
            else                      check("R3 wrong byte stays locked", cfg_open, 0);
            if (cfg_open) relock();
            unlock();
            check("R3 key after wrong byte", cfg_open, 1);
            relock();
            check("R10 relock", cfg_open, 0);
         end
      end

      // R3 restart on 0x87 inside the sequence
      wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h87);
      wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
      check("R3 restart on first key byte", cfg_open, 1);
      relock();
      wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
      wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
      check("R3 broken late key", cfg_open, 0);
      wr(IDX, 8'h22);  // locked index write, must not land in index
      unlock();
      rd(IDX, rv); check("R3 locked index write ignored", rv, 8'h02);

      // R5 identity
      getreg(8'h20, rv); check("R5 id hi", rv, CID[15:8]);
      getreg(8'h21, rv); check("R5 id lo", rv, CID[7:0]);
      getreg(8'h22, rv); check("R5 rev", rv, {4'h0, CREV});
      for (int ix = 8'h20; ix <= 8'h22; ix++) setreg(8'(ix), 8'hA5);
      getreg(8'h20, rv); check("R5 id hi after write", rv, CID[15:8]);
      getreg(8'h21, rv); check("R5 id lo after write", rv, CID[7:0]);
      getreg(8'h22, rv); check("R5 rev after write", rv, {4'h0, CREV});

      // R6..R9 banks, including out-of-range selects
      exp_act = '0; exp_base = '0;
      for (int l = 0; l < NDEV + 3; l++) begin
         logic [7:0] ls;
         logic [7:0] aw;
         ls = (l == NDEV + 2) ? 8'hFF : 8'(l);
         aw = (l == 1) ? 8'hFE : 8'h01;
         setreg(8'h07, ls);
         check("R6 ldn_sel", ldn_sel, ls);
         getreg(8'h07, rv); check("R6 ldn readback", rv, ls);
         setreg(8'h30, aw);
         setreg(8'h60, 8'h10 + ls);
         setreg(8'h61, 8'hC0 ^ ls);
         if (int'(ls) < NDEV) begin
            exp_act[ls] = aw[0];
            exp_base[16*ls +: 16] = {8'h10 + ls, 8'hC0 ^ ls};
         end
         check("R7 dev_active", dev_active, exp_act);
         check("R8 dev_base", dev_base, exp_base);
         getreg(8'h30, rv);
         check(int'(ls) < NDEV ? "R7 act read" : "R9 act read", rv,
               int'(ls) < NDEV ? {7'h0, aw[0]} : 8'h00);
         getreg(8'h60, rv);
         check(int'(ls) < NDEV ? "R8 base hi read" : "R9 base hi read", rv,
               int'(ls) < NDEV ? 8'h10 + ls : 8'h00);
         getreg(8'h61, rv);
         check(int'(ls) < NDEV ? "R8 base lo read" : "R9 base lo read", rv,
               int'(ls) < NDEV ? 8'hC0 ^ ls : 8'h00);
      end
      for (int l = 0; l < NDEV; l++) begin
         setreg(8'h07, 8'(l));
         getreg(8'h60, rv); check("R8 bank retained hi", rv, exp_base[16*l+8 +: 8]);
         getreg(8'h61, rv); check("R8 bank retained lo", rv, exp_base[16*l +: 8]);
      end
      setreg(8'h07, 8'd2); setreg(8'h30, 8'h00);
      exp_act[2] = 1'b0;
      check("R7 clear one bank", dev_active, exp_act);

      // R11 read paths
      wr(IDX, 8'h4D);
      rd(IDX, rv); check("R11 index read open", rv, 8'h4D);
      rd(DAT, rv); check("R11 unassigned index", rv, 8'h00);
      rd(16'h0030, rv); check("R11 other address", rv, 8'h00);

      // R10 exit rules
      setreg(8'h02, 8'h03);
      check("R10 wrong exit code", cfg_open, 1);
      wr(DAT, 8'h02);
      check("R10 exit locks", cfg_open, 0);
      rd(DAT, rv); check("R4 read after exit", rv, 8'hFF);
      wr(DAT, 8'h00); wr(DAT, 8'h07);
      check("R4 locked write act", dev_active, exp_act);
      check("R4 locked write base", dev_base, exp_base);
      unlock();
      getreg(8'h07, rv); check("R4 ldn kept while locked", rv, 8'd2);

      summary();
      $finish;
   end
endmodule